// File: doc/BRIEF.md
# Packet Ingress/Egress Balance Monitor

This block watches the packet traffic around a packet processor and flags behaviour that no legitimate forwarding program could produce. One counter takes a strobe for each packet that starts on the input queue side. A second counter takes a strobe for each packet that starts on the output queue side. Both counters run over an observation window whose length is set in clock cycles. When a window closes, its two totals are captured and judged by a rule that depends on the traffic class.

In unicast mode the processor may drop packets but may never create them, so more outgoing than incoming packets is an anomaly. In multicast mode each incoming packet may fan out to at most N copies, so the outgoing total may reach N times the incoming total. When the rule is broken, the block raises an anomaly pulse and, in the same cycle, a request to flush packet memory and reset the processor.

Top module: `pkt_io_monitor`

## Requirements
- R1: While `rst_n` is low, `in_count`, `out_count`, `anomaly` and `flush_req` are all 0. After release the first window begins on the first rising edge.
- R2: A window lasts `win_len` cycles, and values below 2 mean one cycle. The clock edge that closes a window loads that window's totals into `in_count`/`out_count`, counting a strobe present in the closing cycle. The outputs then hold these totals until the next window closes.
- R3: The live counters restart from zero at every window start, so a window's totals contain only strobes seen inside that window.
- R4: A live counter that reaches 2^CNT_W-1 stays there for the rest of the window and does not wrap.
- R5: With `mcast`=0 (unicast), an anomaly is raised exactly when the captured outgoing total exceeds the captured incoming total. Equal totals, or fewer outgoing packets (for example 4 in and 3 out), are not flagged.
- R6: With `mcast`=1 (multicast), an anomaly is raised exactly when the outgoing total exceeds the incoming total multiplied by `fanout`.
- R7: `anomaly` and `flush_req` rise together for one cycle, on the clock edge after the edge that closed the judged window, and at no other time.
- R8: `mcast` and `fanout` are sampled only on the window-closing edge. A change after that edge does not alter the verdict for the window just closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ing_sop | input | 1 | One-cycle strobe per packet entering the processor |
| egr_sop | input | 1 | One-cycle strobe per packet leaving the processor |
| mcast | input | 1 | Traffic class: 0 unicast, 1 multicast |
| fanout | input | FAN_W | Maximum outgoing copies per incoming packet in multicast mode |
| win_len | input | WIN_W | Observation window length in cycles |
| in_count | output | CNT_W | Incoming total of the last closed window |
| out_count | output | CNT_W | Outgoing total of the last closed window |
| anomaly | output | 1 | One-cycle pulse when the last closed window broke the rule |
| flush_req | output | 1 | One-cycle request to flush packet memory and reset the processor |

## Verification
Two events can fall in the same cycle: a window closing and a new packet strobe arriving. The strobe then has to be added to the closing total while the live counter clears. The bench provokes this by driving strobes through the last cycle of each window, including a full sixteen-of-sixteen window. It judges the result by comparing the captured totals with the strobe count it drove. A second test changes the class inputs on the very edge after a window closes and confirms that the verdict still follows the class that was present at the close.

// File: rtl/io_mon_pkg.sv
package io_mon_pkg;

   typedef enum logic {
      CLS_UNI   = 1'b0,
      CLS_MULTI = 1'b1
   } traffic_cls_e;

endpackage

// File: rtl/io_mon_window.sv
module io_mon_window #(
   parameter int WIN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIN_W-1:0] win_len,
   output logic             boundary
);

   logic [WIN_W-1:0] tick;

   // lengths 0 and 1 both close a window every cycle
   always_comb begin
      if (win_len <= WIN_W'(1))
         boundary = 1'b1;
      else
         boundary = (tick >= (win_len - WIN_W'(1)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick <= '0;
      else if (boundary)
         tick <= '0;
      else
         tick <= tick + WIN_W'(1);
   end

endmodule

// File: rtl/io_mon_counter.sv
module io_mon_counter #(
   parameter int CNT_W  = 16,
   parameter bit SAT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   output logic [CNT_W-1:0] live,
   output logic [CNT_W-1:0] total
);

   localparam logic [CNT_W-1:0] MAXV = '1;

   // total folds in a strobe of the current cycle, so a closing-cycle packet is not lost
   generate
      if (SAT_EN) begin : g_sat
         always_comb begin
            if (inc && (live != MAXV))
               total = live + CNT_W'(1);
            else
               total = live;
         end
      end else begin : g_wrap
         always_comb total = live + CNT_W'(inc);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         live <= '0;
      else if (clear)
         live <= '0;
      else
         live <= total;
   end

endmodule

// File: rtl/io_mon_judge.sv
module io_mon_judge
   import io_mon_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int FAN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary,
   input  logic [CNT_W-1:0] in_total,
   input  logic [CNT_W-1:0] out_total,
   input  traffic_cls_e     cls,
   input  logic [FAN_W-1:0] fanout,
   output logic [CNT_W-1:0] in_count,
   output logic [CNT_W-1:0] out_count,
   output traffic_cls_e     cls_q,
   output logic [FAN_W-1:0] fan_q,
   output logic             anomaly,
   output logic             flush_req
);

   localparam int PROD_W = CNT_W + FAN_W;

   logic              judge_due;
   logic [PROD_W-1:0] allow;
   logic              over;

   always_comb begin
      if (cls_q == CLS_MULTI)
         allow = PROD_W'(in_count) * PROD_W'(fan_q);
      else
         allow = PROD_W'(in_count);
      over = PROD_W'(out_count) > allow;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_count  <= '0;
         out_count <= '0;
         cls_q     <= CLS_UNI;
         fan_q     <= '0;
         judge_due <= 1'b0;
         anomaly   <= 1'b0;
         flush_req <= 1'b0;
      end else begin
         judge_due <= boundary;
         if (boundary) begin
            in_count  <= in_total;
            out_count <= out_total;
            cls_q     <= cls;
            fan_q     <= fanout;
         end
         anomaly   <= judge_due && over;
         flush_req <= judge_due && over;
      end
   end

endmodule

// File: rtl/pkt_io_monitor.sv
module pkt_io_monitor
   import io_mon_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int WIN_W  = 20,
   parameter int FAN_W  = 4,
   parameter bit SAT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ing_sop,
   input  logic             egr_sop,
   input  logic             mcast,
   input  logic [FAN_W-1:0] fanout,
   input  logic [WIN_W-1:0] win_len,
   output logic [CNT_W-1:0] in_count,
   output logic [CNT_W-1:0] out_count,
   output logic             anomaly,
   output logic             flush_req
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("pkt_io_monitor: CNT_W must be at least 2");
      end
      if (WIN_W < 1) begin : g_bad_win
         $error("pkt_io_monitor: WIN_W must be at least 1");
      end
      if (FAN_W < 1) begin : g_bad_fan
         $error("pkt_io_monitor: FAN_W must be at least 1");
      end
   endgenerate

   logic             win_edge;
   logic [CNT_W-1:0] in_live;
   logic [CNT_W-1:0] out_live;
   logic [CNT_W-1:0] in_total;
   logic [CNT_W-1:0] out_total;
   traffic_cls_e     cls_in;
   traffic_cls_e     cls_q;
   logic [FAN_W-1:0] fan_q;
   logic             mcast_q;

   assign cls_in  = mcast ? CLS_MULTI : CLS_UNI;
   assign mcast_q = (cls_q == CLS_MULTI);

   io_mon_window #(.WIN_W(WIN_W)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_len  (win_len),
      .boundary (win_edge)
   );

   io_mon_counter #(.CNT_W(CNT_W), .SAT_EN(SAT_EN)) u_cnt_in (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (win_edge),
      .inc   (ing_sop),
      .live  (in_live),
      .total (in_total)
   );

   io_mon_counter #(.CNT_W(CNT_W), .SAT_EN(SAT_EN)) u_cnt_out (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (win_edge),
      .inc   (egr_sop),
      .live  (out_live),
      .total (out_total)
   );

   io_mon_judge #(.CNT_W(CNT_W), .FAN_W(FAN_W)) u_judge (
      .clk       (clk),
      .rst_n     (rst_n),
      .boundary  (win_edge),
      .in_total  (in_total),
      .out_total (out_total),
      .cls       (cls_in),
      .fanout    (fanout),
      .in_count  (in_count),
      .out_count (out_count),
      .cls_q     (cls_q),
      .fan_q     (fan_q),
      .anomaly   (anomaly),
      .flush_req (flush_req)
   );

endmodule

// File: rtl/io_mon_checker.sv
module io_mon_checker #(
   parameter int CNT_W  = 16,
   parameter int FAN_W  = 4,
   parameter bit SAT_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             boundary,
   input logic             ing_sop,
   input logic [CNT_W-1:0] in_live,
   input logic [CNT_W-1:0] in_count,
   input logic [CNT_W-1:0] out_count,
   input logic             mcast_q,
   input logic [FAN_W-1:0] fan_q,
   input logic             anomaly,
   input logic             flush_req
);

   localparam int PROD_W = CNT_W + FAN_W;
   localparam logic [CNT_W-1:0] MAXV = '1;

   logic [PROD_W-1:0] cap;
   assign cap = PROD_W'(in_count) * PROD_W'(fan_q);

   // R1
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (in_count == '0) && (out_count == '0) && !anomaly && !flush_req);

   // R2
   p_counts_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(in_count) && $stable(out_count));

   // R3
   p_live_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> (in_live == '0));

   // R4
   generate
      if (SAT_EN) begin : g_sat_chk
         p_live_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_live == MAXV) && ing_sop && !boundary |=> (in_live == MAXV));
      end
   endgenerate

   // R5
   p_uni_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(boundary) && !mcast_q && (out_count > in_count) |=> anomaly);
   p_uni_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(boundary) && !mcast_q && (out_count <= in_count) |=> !anomaly);

   // R6
   p_multi_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(boundary) && mcast_q && (PROD_W'(out_count) > cap) |=> anomaly);
   p_multi_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(boundary) && mcast_q && (PROD_W'(out_count) <= cap) |=> !anomaly);

   // R7
   p_pulse_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      anomaly == flush_req);
   p_pulse_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |-> ##2 !anomaly);

   // R8
   p_cls_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(mcast_q) && $stable(fan_q));

endmodule

bind pkt_io_monitor io_mon_checker #(
   .CNT_W  (CNT_W),
   .FAN_W  (FAN_W),
   .SAT_EN (SAT_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .boundary  (win_edge),
   .ing_sop   (ing_sop),
   .in_live   (in_live),
   .in_count  (in_count),
   .out_count (out_count),
   .mcast_q   (mcast_q),
   .fan_q     (fan_q),
   .anomaly   (anomaly),
   .flush_req (flush_req)
);

// File: tb/pkt_io_monitor_bench.sv
module pkt_io_monitor_bench;

   localparam int CNT_W = 5;
   localparam int WIN_W = 8;
   localparam int FAN_W = 3;
   localparam int NVEC  = 12;

   // {nin[14:10], nout[9:5], mcast[4], fanout[3:1], expect_anomaly[0]}
   localparam logic [14:0] VECS [0:NVEC-1] = '{
      {5'd4,  5'd3,  1'b0, 3'd0, 1'b0},
      {5'd3,  5'd3,  1'b0, 3'd0, 1'b0},
      {5'd3,  5'd4,  1'b0, 3'd0, 1'b1},
      {5'd0,  5'd1,  1'b0, 3'd0, 1'b1},
      {5'd0,  5'd0,  1'b0, 3'd0, 1'b0},
      {5'd16, 5'd16, 1'b0, 3'd0, 1'b0},
      {5'd2,  5'd6,  1'b1, 3'd3, 1'b0},
      {5'd2,  5'd7,  1'b1, 3'd3, 1'b1},
      {5'd3,  5'd12, 1'b1, 3'd4, 1'b0},
      {5'd1,  5'd0,  1'b1, 3'd2, 1'b0},
      {5'd0,  5'd1,  1'b1, 3'd5, 1'b1},
      {5'd5,  5'd16, 1'b1, 3'd3, 1'b1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ing_sop = 1'b0;
   logic             egr_sop = 1'b0;
   logic             mcast = 1'b0;
   logic [FAN_W-1:0] fanout = '0;
   logic [WIN_W-1:0] win_len = 8'd16;
   logic [CNT_W-1:0] in_count;
   logic [CNT_W-1:0] out_count;
   logic             anomaly;
   logic             flush_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pkt_io_monitor #(
      .CNT_W (CNT_W),
      .WIN_W (WIN_W),
      .FAN_W (FAN_W)
   ) u_pkt_io_monitor (
      .clk       (clk),
      .rst_n     (rst_n),
      .ing_sop   (ing_sop),
      .egr_sop   (egr_sop),
      .mcast     (mcast),
      .fanout    (fanout),
      .win_len   (win_len),
      .in_count  (in_count),
      .out_count (out_count),
      .anomaly   (anomaly),
      .flush_req (flush_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input int len);
      rst_n   = 1'b0;
      ing_sop = 1'b0;
      egr_sop = 1'b0;
      win_len = WIN_W'(len);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drive_win(input int nin, input int nout, input int len);
      for (int k = 0; k < len; k++) begin
         ing_sop = (k < nin);
         egr_sop = (k < nout);
         @(negedge clk);
      end
      ing_sop = 1'b0;
      egr_sop = 1'b0;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 in_count", int'(in_count), 0);
      chk("R1 out_count", int'(out_count), 0);
      chk("R1 anomaly", int'(anomaly), 0);
      chk("R1 flush_req", int'(flush_req), 0);

      // vector table, one 16-cycle window each
      for (int v = 0; v < NVEC; v++) begin
         int    nin, nout, fan;
         bit    mc, ex;
         string rt;
         nin  = int'(VECS[v][14:10]);
         nout = int'(VECS[v][9:5]);
         mc   = VECS[v][4];
         fan  = int'(VECS[v][3:1]);
         ex   = VECS[v][0];
         rt   = mc ? "R6" : "R5";
         do_reset(16);
         mcast  = mc;
         fanout = FAN_W'(fan);
         drive_win(nin, nout, 16);
         chk("R2 in_count at close", int'(in_count), nin);
         chk("R2 out_count at close", int'(out_count), nout);
         chk("R7 no early pulse", int'(anomaly), 0);
         @(negedge clk);
         chk({rt, " verdict"}, int'(anomaly), int'(ex));
         chk("R7 flush with verdict", int'(flush_req), int'(ex));
         @(negedge clk);
         chk("R7 pulse ends", int'(anomaly), 0);
      end

      // R2 hold and R3 restart across consecutive windows
      do_reset(16);
      mcast = 1'b0;
      drive_win(7, 2, 16);
      repeat (10) @(negedge clk);
      chk("R2 held in_count", int'(in_count), 7);
      chk("R2 held out_count", int'(out_count), 2);
      drive_win(2, 3, 6);
      chk("R3 fresh in_count", int'(in_count), 2);
      chk("R3 fresh out_count", int'(out_count), 3);
      @(negedge clk);
      chk("R5 second window flagged", int'(anomaly), 1);

      // R4 saturation over a 40-cycle window
      do_reset(40);
      mcast = 1'b0;
      drive_win(40, 35, 40);
      chk("R4 in_count saturated", int'(in_count), 31);
      chk("R4 out_count saturated", int'(out_count), 31);
      @(negedge clk);
      chk("R4 equal saturated no flag", int'(anomaly), 0);

      // R2 window length 1: every cycle closes a window
      do_reset(1);
      ing_sop = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 len1 in_count", int'(in_count), 1);
      chk("R2 len1 out_count", int'(out_count), 0);
      ing_sop = 1'b0;
      egr_sop = 1'b1;
      @(negedge clk);
      chk("R2 len1 out latched", int'(out_count), 1);
      @(negedge clk);
      chk("R5 len1 flag", int'(anomaly), 1);
      egr_sop = 1'b0;

      // R8 class changes right after the closing edge
      do_reset(16);
      mcast  = 1'b1;
      fanout = 3'd3;
      drive_win(2, 6, 16);
      mcast  = 1'b0;
      fanout = 3'd0;
      @(negedge clk);
      chk("R8 multicast verdict kept", int'(anomaly), 0);

      do_reset(16);
      mcast  = 1'b0;
      fanout = 3'd0;
      drive_win(2, 3, 16);
      mcast  = 1'b1;
      fanout = 3'd7;
      @(negedge clk);
      chk("R8 unicast verdict kept", int'(anomaly), 1);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule